// File: doc/BRIEF.md
# Strobed Input Handshake Port

This block is the receiving side of a strobed parallel input port. A peripheral places a byte on the data pins and pulses an active-low strobe. The block holds that byte in an input register and raises a buffer-full flag. If interrupts are enabled it also raises an interrupt request once the strobe has ended. The CPU reads the port by pulsing its own active-low read strobe. The leading edge of that read withdraws the interrupt request, and the trailing edge empties the buffer.

The peripheral strobe arrives asynchronously. It passes through a parameterised synchronizer, and the data pins are delayed by the same number of stages so that the stored byte is the one present at the end of the strobe. The CPU read strobe and the enable bit are synchronous to the system clock.

Top module: `strobed_in_port`

## Requirements
- R1: After reset, data_o is 0 and ibf_o, intr_o and status_o are all 0.
- R2: While the synchronised strobe is low, the input register follows the aligned data pins. It keeps the byte that was present in the last clock of the strobe.
- R3: ibf_o goes to 1 within SYNC_STAGES+1 clocks of stb_n_i going low and stays 1 until a read completes.
- R4: ibf_o clears on the rising edge of rd_n_i. A falling edge of rd_n_i, or rd_n_i held low, leaves it set.
- R5: intr_o rises only when, in the previous cycle, the synchronised strobe was high, ibf was 1 and the registered enable was 1. It never rises while the strobe is still low. Raising the enable while a byte is waiting also raises it.
- R6: intr_o clears on the falling edge of rd_n_i and does not rise again for the same byte during or after that read.
- R7: When ien_i is 0, intr_o is 0 from two clocks later on, and ibf_o is unaffected.
- R8: A second strobe while ibf_o is still 1 overwrites the stored byte and leaves ibf_o at 1.
- R9: status_o bit 0 is the buffer-full flag, bit 1 the registered interrupt enable, bit 2 the interrupt request.
- R10: While the synchronised strobe is high, data_o does not change, whatever the data pins do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pdata_i | input | DATA_W | Peripheral data pins |
| stb_n_i | input | 1 | Peripheral strobe, active low, asynchronous |
| rd_n_i | input | 1 | CPU read strobe for this port, active low |
| ien_i | input | 1 | Interrupt enable bit |
| data_o | output | DATA_W | Stored input byte |
| ibf_o | output | 1 | Input buffer full |
| intr_o | output | 1 | Interrupt request, active high |
| status_o | output | 3 | {interrupt request, enable, buffer full} |

## Verification
Assertions check on every clock that the stored byte only moves while the synchronised strobe is low, and that the buffer-full flag sets during a strobe and falls only at the end of a read. They also check that the interrupt rises only under its three-way condition, drops after a read's leading edge and stays low without the enable. Only the bench scenarios show end-to-end behaviour at the pins. That covers which byte survives a strobe whose data changes midway, the overwrite of an unread byte, and the absence of a second interrupt for a byte already being read. It also covers the status bit order.

// File: rtl/hs_pkg.sv
package hs_pkg;
   localparam int STATUS_W = 3;

   typedef struct packed {
      logic intr;
      logic ien;
      logic ibf;
   } hs_status_t;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= {STAGES{RST_VAL}};
      else        sh <= {sh[STAGES-2:0], d};
   end

   assign q = sh[STAGES-1];
endmodule

// File: rtl/hs_delay.sv
module hs_delay #(
   parameter int W     = 8,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] pipe [DEPTH];

   genvar i;
   generate
      for (i = 0; i < DEPTH; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[i] <= '0;
            else if (i == 0) pipe[i] <= d;
            else pipe[i] <= pipe[(i == 0) ? 0 : i-1];
         end
      end
   endgenerate

   assign q = pipe[DEPTH-1];
endmodule

// File: rtl/hs_edge.sv
module hs_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_n,
   output logic rd_rise,
   output logic rd_fall
);
   logic rd_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_prev <= 1'b1;
      else        rd_prev <= rd_n;
   end

   assign rd_rise = rd_n & ~rd_prev;
   assign rd_fall = ~rd_n & rd_prev;
endmodule

// File: rtl/hs_flags.sv
module hs_flags #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         stb_s,
   input  logic [W-1:0] din,
   input  logic         rd_n,
   input  logic         rd_rise,
   input  logic         rd_fall,
   input  logic         ien_i,
   output logic [W-1:0] data_q,
   output logic         ibf_q,
   output logic         intr_q,
   output logic         ien_q
);
   logic intr_set;

   assign intr_set = stb_s & ibf_q & ien_q & rd_n & ~rd_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         ibf_q  <= 1'b0;
         intr_q <= 1'b0;
         ien_q  <= 1'b0;
      end else begin
         ien_q <= ien_i;
         if (!stb_s) data_q <= din;
         ibf_q  <= ~stb_s | (ibf_q & ~rd_rise);
         intr_q <= ien_q & ~rd_fall & (intr_q | intr_set);
      end
   end

   a_r3_ibf_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !stb_s |=> ibf_q);
   a_r4_ibf_clear_on_read_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ibf_q) |-> $past(rd_rise));
   a_r5_intr_rise_cond: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(intr_q) |-> ($past(stb_s) && $past(ibf_q) && $past(ien_q)));
   a_r6_intr_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      rd_fall |=> !intr_q);
   a_r7_no_intr_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      !ien_q |=> !intr_q);
   a_r10_hold_when_high: assert property (@(posedge clk) disable iff (!rst_n)
      stb_s |=> $stable(data_q));
endmodule

// File: rtl/strobed_in_port.sv
module strobed_in_port #(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit ALIGN_DATA  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] pdata_i,
   input  logic              stb_n_i,
   input  logic              rd_n_i,
   input  logic              ien_i,
   output logic [DATA_W-1:0] data_o,
   output logic              ibf_o,
   output logic              intr_o,
   output logic [2:0]        status_o
);
   import hs_pkg::*;

   generate
      if (DATA_W < 1) begin : g_bad_w
         $error("DATA_W must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic              stb_s;
   logic [DATA_W-1:0] din_al;
   logic              rd_rise, rd_fall;
   logic              ibf, intr, ien;
   hs_status_t        st;

   hs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(stb_n_i), .q(stb_s));

   generate
      if (ALIGN_DATA) begin : g_align
         hs_delay #(.W(DATA_W), .DEPTH(SYNC_STAGES)) u_dly (
            .clk(clk), .rst_n(rst_n), .d(pdata_i), .q(din_al));
      end else begin : g_raw
         assign din_al = pdata_i;
      end
   endgenerate

   hs_edge u_edge (
      .clk(clk), .rst_n(rst_n), .rd_n(rd_n_i),
      .rd_rise(rd_rise), .rd_fall(rd_fall));

   hs_flags #(.W(DATA_W)) u_flags (
      .clk(clk), .rst_n(rst_n), .stb_s(stb_s), .din(din_al),
      .rd_n(rd_n_i), .rd_rise(rd_rise), .rd_fall(rd_fall), .ien_i(ien_i),
      .data_q(data_o), .ibf_q(ibf), .intr_q(intr), .ien_q(ien));

   assign st.intr = intr;
   assign st.ien  = ien;
   assign st.ibf  = ibf;

   assign ibf_o    = ibf;
   assign intr_o   = intr;
   assign status_o = st;
endmodule

// File: tb/sim_strobed_in_port.sv
`timescale 1ns/1ps
module sim_strobed_in_port;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] pdata_i = 8'h00;
   logic       stb_n_i = 1'b1;
   logic       rd_n_i = 1'b1;
   logic       ien_i = 1'b0;
   logic [7:0] data_o;
   logic       ibf_o, intr_o;
   logic [2:0] status_o;

   int  n_run = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   always #2.5 clk = ~clk;

   strobed_in_port u0 (
      .clk(clk), .rst_n(rst_n), .pdata_i(pdata_i), .stb_n_i(stb_n_i),
      .rd_n_i(rd_n_i), .ien_i(ien_i), .data_o(data_o), .ibf_o(ibf_o),
      .intr_o(intr_o), .status_o(status_o));

   // {data, enable, expected interrupt}
   localparam logic [9:0] VEC [6] = '{
      {8'hA5, 1'b1, 1'b1}, {8'h00, 1'b0, 1'b0}, {8'hFF, 1'b1, 1'b1},
      {8'h3C, 1'b0, 1'b0}, {8'h81, 1'b1, 1'b1}, {8'h5A, 1'b0, 1'b0}};

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic strobe(input logic [7:0] d, input int low);
      @(negedge clk);
      pdata_i = d;
      stb_n_i = 1'b0;
      cyc(low);
      stb_n_i = 1'b1;
   endtask

   task automatic do_read();
      @(negedge clk);
      rd_n_i = 1'b0;
      cyc(3);
      check("R6 intr low during read", intr_o, 0);
      check("R4 ibf held while read low", ibf_o, 1);
      rd_n_i = 1'b1;
      cyc(3);
      check("R4 ibf cleared after read", ibf_o, 0);
      check("R6 no re-raise after read", intr_o, 0);
   endtask

   initial begin
      cyc(3);
      check("R1 data after reset", data_o, 0);
      check("R1 ibf after reset", ibf_o, 0);
      check("R1 intr after reset", intr_o, 0);
      check("R1 status after reset", status_o, 0);
      rst_n = 1'b1;
      cyc(2);

      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         ien_i = VEC[k][1];
         cyc(3);
         strobe(VEC[k][9:2], 3);
         cyc(5);
         check("R2 latched byte", data_o, VEC[k][9:2]);
         check("R3 ibf set", ibf_o, 1);
         check("R5 intr per enable", intr_o, VEC[k][0]);
         check("R9 status bits", status_o, {VEC[k][0], VEC[k][1], 1'b1});
         do_read();
      end

      // R3 timing and R5 no interrupt while strobe low
      @(negedge clk);
      ien_i = 1'b1;
      cyc(3);
      pdata_i = 8'h11;
      stb_n_i = 1'b0;
      cyc(3);
      check("R3 ibf within SYNC_STAGES+1", ibf_o, 1);
      cyc(3);
      check("R5 no intr while strobe low", intr_o, 0);
      pdata_i = 8'h22;
      cyc(3);
      stb_n_i = 1'b1;
      pdata_i = 8'hEE;
      cyc(5);
      check("R2 last byte of strobe kept", data_o, 8'h22);
      check("R10 data held after strobe", data_o, 8'h22);
      check("R5 intr after strobe ends", intr_o, 1);

      // R8 overwrite while full
      strobe(8'h77, 3);
      cyc(5);
      check("R8 overwrite data", data_o, 8'h77);
      check("R8 ibf stays set", ibf_o, 1);

      // R7 enable drop clears interrupt, R5 re-enable raises it
      @(negedge clk);
      ien_i = 1'b0;
      cyc(3);
      check("R7 intr cleared by enable", intr_o, 0);
      check("R7 ibf unaffected", ibf_o, 1);
      check("R9 status with enable off", status_o, 3'b001);
      ien_i = 1'b1;
      cyc(3);
      check("R5 intr on late enable", intr_o, 1);
      check("R9 status all set", status_o, 3'b111);
      pdata_i = 8'h99;
      cyc(3);
      check("R10 data pins ignored", data_o, 8'h77);
      do_read();

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule